// File: doc/BRIEF.md
# Fixed-Point Tensor Mode Contraction Engine

This block contracts one p×p operator matrix against the first index of one p×p×p tensor, the basic step of a tensor-product spectral operator. The matrix and the tensor arrive on two independent valid/ready input streams. Each stream is held in its own local array, because the loop nest reads the operands out of arrival order. Once both arrays are complete, the block emits the p×p×p result on a valid/ready output stream and marks the final word with a last flag.

Each result word is a dot product of length p. The p products are formed in parallel, and a chain of p adders sums them, one word per accepted output handshake. All words use a signed 32-bit fixed-point format with 8 integer and 24 fractional bits. The element size `P` is an elaboration parameter, meant to be 7 or 11. The block sits between a read stage and a write stage of a streaming pipeline. It holds one element at a time.

Top module: `tensor_mode_contract`

## Requirements
- R1: Words are signed two's-complement fixed point with 24 fractional bits. Each product is the full signed 64-bit product of its two operands with bits [55:24] kept, which is an arithmetic right shift by 24 followed by truncation to 32 bits.
- R2: The p products of a result word are added in index order starting from zero, and every addition wraps modulo 2^32 with no saturation.
- R3: Matrix word number k arrives as M[k/P][k%P]. Tensor word number k arrives as X[k/(P*P)][(k/P)%P][k%P]. The result is R[a][b][c] = sum over m of M[a][m]·X[m][b][c].
- R4: Results leave in row-major order with c varying fastest. `res_last` is high on the P³-th word only.
- R5: No result is presented until all P² matrix words and all P³ tensor words have been accepted. The two input streams fill independently and in any interleaving.
- R6: While a result is draining, both input readies are low. After the handshake on the last word, `res_valid` falls and both readies return high on the next cycle.
- R7: While `res_valid` is high and `res_ready` is low, `res_data` and `res_last` hold their values.
- R8: After reset, `res_valid` is low and both input readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mat_valid | input | 1 | Matrix word valid |
| mat_ready | output | 1 | Matrix word accepted when high with valid |
| mat_data | input | 32 | Matrix word, Q8.24 |
| ten_valid | input | 1 | Tensor word valid |
| ten_ready | output | 1 | Tensor word accepted when high with valid |
| ten_data | input | 32 | Tensor word, Q8.24 |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Downstream accepts result word |
| res_data | output | 32 | Result word, Q8.24 |
| res_last | output | 1 | Marks the final result word of the element |

## Verification
The assertions check the stream protocol on every cycle. They cover blocked inputs during draining, held output under backpressure, the position of the last flag counted against handshakes, the return to loading after the last word, and full input buffers before the first result. The numeric behaviour can only be shown by the bench scenarios, which compare every word against a reference contraction: truncating products, wrapping sums, and index ordering. The bench uses an identity operator, pseudo-random full-range words, large values that force wrap, and negative scalings. It also runs both sequential and interleaved input loading, under steady and irregular downstream backpressure.

// File: rtl/tensor_mode_contract.sv
module tensor_mode_contract #(
  parameter int P    = 7,
  parameter int W    = 32,
  parameter int FRAC = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mat_valid,
  output logic         mat_ready,
  input  logic [W-1:0] mat_data,
  input  logic         ten_valid,
  output logic         ten_ready,
  input  logic [W-1:0] ten_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_data,
  output logic         res_last
);
  localparam int MN  = P * P;
  localparam int TN  = P * P * P;
  localparam int MCW = $clog2(MN + 1);
  localparam int TCW = $clog2(TN + 1);
  localparam int MAW = $clog2(MN);
  localparam int TAW = $clog2(TN);
  localparam int AW  = $clog2(P);

  logic [W-1:0]   mat_mem [MN];
  logic [W-1:0]   ten_mem [TN];
  logic [MCW-1:0] mcnt;
  logic [TCW-1:0] tcnt;
  logic           emit;
  logic [AW-1:0]  ia;
  logic [MAW-1:0] ibc;

  logic mat_full, ten_full, row_end;
  assign mat_full  = (mcnt == MCW'(MN));
  assign ten_full  = (tcnt == TCW'(TN));
  assign mat_ready = !emit && !mat_full;
  assign ten_ready = !emit && !ten_full;
  assign row_end   = (ibc == MAW'(MN - 1));
  assign res_valid = emit;
  assign res_last  = emit && row_end && (ia == AW'(P - 1));

  always_ff @(posedge clk) begin
    if (mat_valid && mat_ready) mat_mem[mcnt[MAW-1:0]] <= mat_data;
    if (ten_valid && ten_ready) ten_mem[tcnt[TAW-1:0]] <= ten_data;
  end

  logic [W-1:0] chain [P+1];
  assign chain[0] = '0;

  for (genvar g = 0; g < P; g++) begin : g_lane
    logic [MAW-1:0]          maddr;
    logic [TAW-1:0]          taddr;
    logic signed [2*W-1:0]   full;
    assign maddr = MAW'(int'(ia) * P + g);
    assign taddr = TAW'(g * MN + int'(ibc));
    assign full  = $signed(mat_mem[maddr]) * $signed(ten_mem[taddr]);
    assign chain[g+1] = chain[g] + full[FRAC+W-1:FRAC];
  end

  assign res_data = chain[P];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt <= '0;
      tcnt <= '0;
      emit <= 1'b0;
      ia   <= '0;
      ibc  <= '0;
    end else begin
      if (mat_valid && mat_ready) mcnt <= mcnt + 1'b1;
      if (ten_valid && ten_ready) tcnt <= tcnt + 1'b1;
      if (!emit && mat_full && ten_full) emit <= 1'b1;
      if (res_valid && res_ready) begin
        if (res_last) begin
          emit <= 1'b0;
          mcnt <= '0;
          tcnt <= '0;
          ia   <= '0;
          ibc  <= '0;
        end else if (row_end) begin
          ibc <= '0;
          ia  <= ia + 1'b1;
        end else begin
          ibc <= ibc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tensor_mode_contract_chk.sv
module tensor_mode_contract_chk #(
  parameter int P = 7,
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mat_ready,
  input logic         ten_ready,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_data,
  input logic         res_last
);
  localparam int TN  = P * P * P;
  localparam int TCW = $clog2(TN + 1);

  logic [TCW-1:0] ocnt;
  always_ff @(posedge clk) begin
    if (!rst_n) ocnt <= '0;
    else if (res_valid && res_ready) ocnt <= res_last ? '0 : ocnt + 1'b1;
  end

  // R6
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!mat_ready && !ten_ready));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && res_last) |=> (!res_valid && mat_ready && ten_ready));

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_last)));

  // R4
  last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_last == (ocnt == TCW'(TN - 1))));

  // R5
  full_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(!mat_ready && !ten_ready));
endmodule

bind tensor_mode_contract tensor_mode_contract_chk #(.P(P), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mat_ready(mat_ready), .ten_ready(ten_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_last(res_last)
);

// File: tb/tb_tensor_mode_contract.sv
module tb_tensor_mode_contract;
  localparam int P      = 7;
  localparam int MN     = P * P;
  localparam int TN     = P * P * P;
  localparam int CLK_NS = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        mat_valid = 0, ten_valid = 0, res_ready = 0;
  logic [31:0] mat_data = 0, ten_data = 0;
  logic        mat_ready, ten_ready, res_valid, res_last;
  logic [31:0] res_data;

  int checks = 0, fails = 0;
  logic [31:0] M [MN];
  logic [31:0] X [TN];
  logic [31:0] E [TN];
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_NS/2) clk = ~clk;

  tensor_mode_contract #(.P(P)) dut (
    .clk(clk), .rst_n(rst_n),
    .mat_valid(mat_valid), .mat_ready(mat_ready), .mat_data(mat_data),
    .ten_valid(ten_valid), .ten_ready(ten_ready), .ten_data(ten_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_last(res_last)
  );

  function automatic logic [31:0] next_rng();
    rng = rng * 32'd1664525 + 32'd1013904223;
    return rng;
  endfunction

  function automatic logic [31:0] fx_mul(logic [31:0] a, logic [31:0] b);
    logic signed [63:0] f;
    f = $signed(a) * $signed(b);
    return f[55:24];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R3 reference contraction, R1 product truncation, R2 wrapping sum
  task automatic build_ref();
    for (int a = 0; a < P; a++)
      for (int bc = 0; bc < MN; bc++) begin
        logic [31:0] s;
        s = 0;
        for (int m = 0; m < P; m++) s = s + fx_mul(M[a*P+m], X[m*MN+bc]);
        E[a*MN+bc] = s;
      end
  endtask

  task automatic fill(int mode);
    for (int k = 0; k < MN; k++)
      case (mode)
        0: M[k] = (k / P == k % P) ? 32'h0100_0000 : 32'h0;
        1: M[k] = next_rng();
        2: M[k] = 32'h7F00_0000 - k;
        default: M[k] = 32'hFF80_0000;
      endcase
    for (int k = 0; k < TN; k++)
      case (mode)
        1: X[k] = next_rng();
        2: X[k] = 32'h7E00_0000 + (k << 8);
        default: X[k] = {{8{rng[31]}}, next_rng() >> 8};
      endcase
    build_ref();
  endtask

  task automatic send_mat();
    for (int k = 0; k < MN; k++) begin
      @(negedge clk);
      mat_valid = 1; mat_data = M[k];
      while (!mat_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); mat_valid = 0;
  endtask

  task automatic send_ten(int from, int to, bit gaps);
    for (int k = from; k < to; k++) begin
      @(negedge clk);
      if (gaps && next_rng()[20]) begin
        ten_valid = 0;
        @(negedge clk);
      end
      ten_valid = 1; ten_data = X[k];
      while (!ten_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); ten_valid = 0;
  endtask

  task automatic drain(bit bp);
    int got = 0;
    bit held = 0;
    logic [31:0] hd;
    logic hl;
    while (got < TN) begin
      @(negedge clk);
      if (held) begin
        // R7 output stays put while stalled
        check(res_valid && res_data == hd && res_last == hl, "R7", res_data, hd);
        held = 0;
      end
      res_ready = bp ? next_rng()[17] : 1'b1;
      if (res_valid) begin
        if (got == 0) check(!mat_ready && !ten_ready, "R6", {mat_ready, ten_ready}, 0);
        if (res_ready) begin
          check(res_data == E[got], "R3", res_data, E[got]);
          check(res_last == (got == TN - 1), "R4", res_last, got == TN - 1);
          got++;
        end else begin
          held = 1; hd = res_data; hl = res_last;
        end
      end
    end
    @(negedge clk);
    res_ready = 0;
    check(!res_valid && mat_ready && ten_ready, "R6", {res_valid, mat_ready, ten_ready}, 3'b011);
  endtask

  task automatic run(int mode, bit interleave, bit bp);
    fill(mode);
    if (interleave) begin
      fork
        send_mat();
        send_ten(0, TN, 1);
      join
    end else begin
      send_mat();
      send_ten(0, TN - 1, 0);
      repeat (3) @(negedge clk);
      // R5 nothing before the final tensor word
      check(!res_valid && ten_ready && !mat_ready, "R5", {res_valid, ten_ready, mat_ready}, 3'b010);
      send_ten(TN - 1, TN, 0);
    end
    drain(bp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    check(!res_valid && mat_ready && ten_ready, "R8", {res_valid, mat_ready, ten_ready}, 3'b011);
    run(0, 0, 0);   // R3 identity operator
    run(1, 1, 1);   // R1 R2 full-range words, interleaved, backpressure
    run(2, 0, 1);   // R2 forced wrap
    run(3, 1, 0);   // R1 negative scaling truncation
    run(1, 1, 1);   // R5 second random element
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule